// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Device Model

This block is a synthesizable stand-in for the device side of a 16-bit asynchronous static RAM that has two byte selects. A memory controller under test drives active-low chip enable, output enable, write enable, an upper-lane select, a lower-lane select, an address and write data. The model answers the way the real part would, following the full mode table for each byte lane on its own: deselected, output off, read, and lane-masked write.

Everything is sampled on a local clock that is much faster than the controller's bus cycle. A write lands in the array on the edge that samples it. Read data appears a fixed number of sampling clocks after the address or the lane selects settle, and until then the previous value stays on the bus, which models output hold. Each lane has its own data-out bus and its own drive flag, so a pad wrapper can build the tri-state bus from them.

Top module: `sram_lane_model`

## Requirements
- R1: When `ce_n` is high at a sampling edge, both bits of `dq_oe` are 0 after that edge, and no lane is written whatever `we_n` and the selects are.
- R2: When `ce_n` is low and both `we_n` and `oe_n` are high, both bits of `dq_oe` are 0 after the edge, and nothing is written.
- R3: When `ce_n` is low and both `ub_n` and `lb_n` are high, both bits of `dq_oe` are 0 after the edge, and nothing is written.
- R4: A read (`ce_n`=0, `we_n`=1, `oe_n`=0) with only `lb_n` low gives `dq_oe`=2'b01 and the stored low byte on `dq_out[7:0]`; with only `ub_n` low it gives `dq_oe`=2'b10 and the stored high byte on `dq_out[15:8]`. Bit 0 of `dq_oe` is the lower lane, bit 1 the upper lane.
- R5: A read with both selects low gives `dq_oe`=2'b11 and the whole stored word on `dq_out`.
- R6: A write (`ce_n`=0, `we_n`=0) stores `dq_in[7:0]` when `lb_n` is low and `dq_in[15:8]` when `ub_n` is low, leaving the other lane's stored byte untouched, whatever the level of `oe_n`.
- R7: Read data and its drive flag appear on the RD_LAT-th rising edge at which a read of the same address has been held on that lane (default RD_LAT=2); before that edge a lane that was not driving stays at `dq_oe`=0.
- R8: When the address changes during an active read, each active lane keeps its previous `dq_out` byte and its drive flag until the new data loads RD_LAT edges later.
- R9: A write sampled on a lane that was driving read data releases that lane's `dq_oe` bit at the edge that samples the write.
- R10: A stored word stays unchanged across any number of reads, idle cycles and writes to other addresses.
- R11: While `rst_n` is low at a rising edge, `dq_oe` becomes 2'b00 and `dq_out` becomes 0; the stored array is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than the bus cycle |
| rst_n | input | 1 | Synchronous active-low reset of the output side |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper lane select (bits 15:8), active low |
| lb_n | input | 1 | Lower lane select (bits 7:0), active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Write data from the bus |
| dq_out | output | 2*LANE_W | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive flag, bit 0 lower lane |

## Verification
On every cycle the assertions check that deselection, output-off, unselected lanes and writes leave both lanes undriven after the next edge, that a lane only starts driving after its own select was low during a read, and that the data byte holds steady through the first edge after an address change. Whether the right bytes were stored, whether masked lanes kept their old contents, and whether the data that finally appears matches the array can only be shown by the bench's scenarios, which compare read-back data against a word-level model after random mixes of writes, reads and idle modes.

// File: rtl/sram_model_pkg.sv
// Package: shared types for the byte-lane SRAM device model.
// Assumes two byte lanes, lane 0 = low byte, lane 1 = high byte.
package sram_model_pkg;

    localparam int LANES = 2;

    // Chip-level operating mode decoded from the control pins.
    typedef enum logic [1:0] {
        CHIP_DESELECT = 2'd0,
        CHIP_OUT_OFF  = 2'd1,
        CHIP_READ     = 2'd2,
        CHIP_WRITE    = 2'd3
    } chip_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
// Module: sram_mode_decode
// Turns the active-low control pins into a chip mode and one write
// strobe and one read request per byte lane.
// Assumes: write has priority over output enable (a write occurs
// whatever oe_n is), and deselection overrides everything.
module sram_mode_decode
    import sram_model_pkg::*;
(
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [LANES-1:0] sel_n,
    output chip_mode_e       mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);

    // Chip mode from the three control pins.
    always_comb begin
        if (ce_n)       mode = CHIP_DESELECT;
        else if (!we_n) mode = CHIP_WRITE;
        else if (!oe_n) mode = CHIP_READ;
        else            mode = CHIP_OUT_OFF;
    end

    // Per-lane strobes gated by the lane selects.
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane_wr[l] = (mode == CHIP_WRITE) && !sel_n[l];
            assign lane_rd[l] = (mode == CHIP_READ)  && !sel_n[l];
        end
    endgenerate

endmodule

// File: rtl/sram_lane_store.sv
// Module: sram_lane_store
// The word array, kept as one byte-wide memory per lane so that a
// masked write touches only its own lane.
// Assumes: no reset on the array (stored data survives reset, as a
// static RAM does); the read port is combinational from addr.
module sram_lane_store #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wr_en,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] cells [DEPTH];

            // Store this lane's byte when its write strobe is sampled.
            always_ff @(posedge clk) begin
                if (wr_en[l]) cells[addr] <= din[l*LANE_W +: LANE_W];
            end

            // Present this lane's byte of the addressed word.
            assign rd_word[l*LANE_W +: LANE_W] = cells[addr];
        end
    endgenerate

endmodule

// File: rtl/sram_lane_timer.sv
// Module: sram_lane_timer
// Read timing for one lane: counts how many edges a read of the same
// address has been held and loads the output byte on the RD_LAT-th.
// Until then the previous byte and drive state are kept (output hold).
// Assumes: RD_LAT >= 1; addr_chg compares addr with its value at the
// previous edge.
module sram_lane_timer #(
    parameter int LANE_W = 8,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  logic              addr_chg,
    input  logic [LANE_W-1:0] mem_byte,
    output logic [LANE_W-1:0] dout,
    output logic              drive
);

    localparam int              CNT_W = (RD_LAT < 2) ? 1 : $clog2(RD_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(RD_LAT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nxt;
    logic             load;

    initial begin
        a_lat_legal: assert (RD_LAT >= 1);
    end

    // Length of the current unchanged read run including this edge.
    always_comb begin
        if (run_q != '0 && !addr_chg)
            run_nxt = (run_q == LAT_C) ? run_q : run_q + ONE_C;
        else
            run_nxt = ONE_C;
        load = rd_act && (run_nxt == LAT_C);
    end

    // Run counter, output byte and drive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            dout  <= '0;
            drive <= 1'b0;
        end else if (!rd_act) begin
            run_q <= '0;
            drive <= 1'b0;
        end else begin
            run_q <= run_nxt;
            if (load) begin
                dout  <= mem_byte;
                drive <= 1'b1;
            end
        end
    end

    // R8: with more than one cycle of latency the byte holds through the
    // first edge after an address change.
    generate
        if (RD_LAT > 1) begin : g_hold_chk
            p_hold_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (drive && rd_act && addr_chg) |=> ($stable(dout) && drive));
        end
    endgenerate

endmodule

// File: rtl/sram_lane_model.sv
// Module: sram_lane_model (top)
// Device-side model of a 16-bit asynchronous SRAM with byte selects,
// sampled on clk. Writes land on the sampling edge; reads appear after
// RD_LAT edges of a stable request, one drive flag per lane.
// Assumes: clk is fast enough to see every bus phase; the pad wrapper
// builds the tri-state bus from dq_out and dq_oe.
module sram_lane_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int RD_LAT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    oe_n,
    input  logic                    we_n,
    input  logic                    ub_n,
    input  logic                    lb_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [2*LANE_W-1:0]     dq_in,
    output logic [2*LANE_W-1:0]     dq_out,
    output logic [1:0]              dq_oe
);

    localparam int WORD_W = LANES * LANE_W;

    chip_mode_e        mode;
    logic [LANES-1:0]  sel_n;
    logic [LANES-1:0]  lane_wr;
    logic [LANES-1:0]  lane_rd;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] addr_q;
    logic              addr_chg;

    assign sel_n = {ub_n, lb_n};

    sram_mode_decode u_decode (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .sel_n   (sel_n),
        .mode    (mode),
        .lane_wr (lane_wr),
        .lane_rd (lane_rd)
    );

    sram_lane_store #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_store (
        .clk     (clk),
        .addr    (addr),
        .wr_en   (lane_wr),
        .din     (dq_in),
        .rd_word (rd_word)
    );

    // Address seen at the previous edge, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr;
    end

    assign addr_chg = (addr != addr_q);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            sram_lane_timer #(
                .LANE_W (LANE_W),
                .RD_LAT (RD_LAT)
            ) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .rd_act   (lane_rd[l]),
                .addr_chg (addr_chg),
                .mem_byte (rd_word[l*LANE_W +: LANE_W]),
                .dout     (dq_out[l*LANE_W +: LANE_W]),
                .drive    (dq_oe[l])
            );
        end
    endgenerate

    // R1: deselection releases both lanes.
    p_deselect_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dq_oe == 2'b00));

    // R2: output-off mode releases both lanes.
    p_out_off_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> (dq_oe == 2'b00));

    // R3: with no lane selected nothing is driven.
    p_no_select_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ub_n && lb_n) |=> (dq_oe == 2'b00));

    // R9: a sampled write releases the bus.
    p_write_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (dq_oe == 2'b00));

    // R4: a lane only starts driving after its own select was low in a read.
    p_low_lane_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> $past(!lb_n && !ce_n && we_n && !oe_n));
    p_high_lane_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[1]) |-> $past(!ub_n && !ce_n && we_n && !oe_n));

endmodule

// File: tb/sram_lane_model_test.sv
module sram_lane_model_test;

    localparam int AW  = 8;
    localparam int LAT = 2;
    localparam int NW  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;

    logic [15:0]   model [NW];
    int            errors = 0;
    int            checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    sram_lane_model #(.ADDR_W(AW), .LANE_W(8), .RD_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ce, input logic oe, input logic we, input logic ub,
                         input logic lb, input logic [AW-1:0] a, input logic [15:0] d);
        ce_n = ce; oe_n = oe; we_n = we; ub_n = ub; lb_n = lb; addr = a; dq_in = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        step();
    endtask

    function automatic logic [15:0] lane_mask(input logic ub, input logic lb);
        return {{8{~ub}}, {8{~lb}}};
    endfunction

    // Read held for LAT edges, then compare drive flags and selected bytes.
    task automatic do_read(input logic [AW-1:0] a, input logic ub, input logic lb, input string tag);
        logic [15:0] m;
        drive(1'b0, 1'b0, 1'b1, ub, lb, a, '0);
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        m = lane_mask(ub, lb);
        chk({tag, " drive"}, {14'd0, dq_oe}, {14'd0, ~ub, ~lb});
        chk({tag, " data"}, dq_out & m, model[a] & m);
    endtask

    // One sampled write; the bus must be released after it.
    task automatic do_write(input logic [AW-1:0] a, input logic ub, input logic lb,
                            input logic oe, input logic [15:0] d);
        drive(1'b0, oe, 1'b0, ub, lb, a, d);
        step();
        if (!lb) model[a][7:0]  = d[7:0];
        if (!ub) model[a][15:8] = d[15:8];
        chk("R9 write release", {14'd0, dq_oe}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));

        // R11: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset drive", {14'd0, dq_oe}, 16'd0);
        chk("R11 reset data", dq_out, 16'd0);
        rst_n = 1'b1;
        step();

        // Fill the array with a known pattern.
        for (int i = 0; i < NW; i++) begin
            drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(i), 16'(i * 257) ^ 16'hA5C3);
            step();
            model[i] = 16'(i * 257) ^ 16'hA5C3;
        end
        go_idle();

        // R7: nothing driven after one edge, data after LAT edges.
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5, '0);
        step();
        chk("R7 early drive", {14'd0, dq_oe}, 16'd0);
        step();
        chk("R7 on-time drive", {14'd0, dq_oe}, 16'd3);
        chk("R5 full word", dq_out, model[5]);

        // R8: address change holds the old word for one edge.
        addr = 8'd6;
        step();
        chk("R8 held data", dq_out, model[5]);
        chk("R8 held drive", {14'd0, dq_oe}, 16'd3);
        step();
        chk("R8 new data", dq_out, model[6]);

        // R9 and R6: write low lane over an active read, high lane kept.
        do_write(8'd6, 1'b1, 1'b0, 1'b1, 16'h3C7E);
        go_idle();
        do_read(8'd6, 1'b0, 1'b0, "R6 low lane only");

        // R6: write with oe_n low stores only the high lane.
        go_idle();
        do_write(8'd9, 1'b0, 1'b1, 1'b0, 16'hD218);
        go_idle();
        do_read(8'd9, 1'b0, 1'b0, "R6 write under oe_n low");

        // R4: single-lane reads.
        go_idle();
        do_read(8'd9, 1'b1, 1'b0, "R4 low lane read");
        go_idle();
        do_read(8'd9, 1'b0, 1'b1, "R4 high lane read");

        // R10: word kept across writes elsewhere and idle cycles.
        go_idle();
        do_write(8'd7, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        for (int i = 10; i < 40; i++) do_write(AW'(i), 1'b0, 1'b0, 1'b1, 16'(i * 3));
        go_idle();
        repeat (5) step();
        do_read(8'd7, 1'b0, 1'b0, "R10 retention");
        go_idle();

        // Random mix of all modes with read-back after non-storing ops.
        for (int it = 0; it < 400; it++) begin
            int          kind;
            logic [AW-1:0] a;
            logic [1:0]  s;
            logic [15:0] d;
            kind = int'($urandom_range(0, 3));
            a    = AW'($urandom_range(0, NW - 1));
            s    = 2'($urandom_range(0, 3));
            d    = 16'($urandom);
            case (kind)
                0: begin
                    do_write(a, s[1], s[0], 1'($urandom_range(0, 1)), d);
                    go_idle();
                    do_read(a, 1'b0, 1'b0, "R6 random write");
                end
                1: begin
                    do_read(a, s[1], s[0], (s == 2'b11) ? "R3 random read" : "R4 random read");
                end
                2: begin
                    drive(1'b0, 1'b1, 1'b1, s[1], s[0], a, d);
                    step();
                    chk("R2 output off", {14'd0, dq_oe}, 16'd0);
                    go_idle();
                    do_read(a, 1'b0, 1'b0, "R2 no store");
                end
                default: begin
                    drive(1'b1, 1'($urandom_range(0, 1)), 1'b0, s[1], s[0], a, d);
                    step();
                    chk("R1 deselect", {14'd0, dq_oe}, 16'd0);
                    go_idle();
                    do_read(a, 1'b0, 1'b0, "R1 no store");
                end
            endcase
            go_idle();
        end

        // R3: write with no lane selected changes nothing.
        do_write(8'd200, 1'b1, 1'b1, 1'b1, 16'h0F0F);
        go_idle();
        do_read(8'd200, 1'b0, 1'b0, "R3 masked write");
        go_idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule